// File: doc/BRIEF.md
# Horizontal Crop Unit

This block sits in a pixel pipeline between a line fetcher and a compositor. It receives a raster stream whose lines are as wide as the whole source buffer and forwards only a horizontal window of each line. It drops a programmable number of leading pixels and a programmable number of trailing pixels from every line. Lines are never removed, so the output frame has the same line count as the input frame, only narrower.

Both streams use valid/ready handshakes and carry a start-of-frame marker on the first pixel and an end-of-line marker on the last pixel of each line. The block makes new start-of-frame and end-of-line markers so that they fall on kept pixels. Settings are taken at frame start, so a frame is never split between two configurations. A hold input keeps the running settings across frame starts. A bypass input, or a window that covers the full line, sends the stream through unchanged.

Top module: `hcrop_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Counting columns from 0 at the start-of-frame pixel and after every input end-of-line, a pixel at column c is forwarded, in order and with unchanged data, exactly when c >= L and c + T + 1 < W. All other pixels are consumed and produce no output.
- R3: `cfg_width_m1` holds W-1. `cfg_clip[31:16]` holds the leading drop count L. `cfg_clip[15:0]` holds T, which is the number of pixels that follow the window, minus one.
- R4: When cropping, `out_eol` is 1 only on the forwarded pixel with c + T + 1 = W-1. The input end-of-line pixel is dropped. Each line with a non-empty window yields exactly one output end-of-line.
- R5: When cropping, `out_sof` is 1 on the first forwarded pixel of a frame, even when the input start-of-frame pixel itself was dropped, and on no other pixel.
- R6: While the active bypass setting is 1, every input pixel is forwarded with its data, start-of-frame and end-of-line unchanged.
- R7: Active settings with L = 0 and T = 16'hFFFF (a full-width window) behave exactly as bypass.
- R8: The settings on the configuration inputs are captured when a start-of-frame pixel is accepted, and they apply to that pixel. Changes made later in the frame have no effect until the next start of frame.
- R9: While `cfg_hold` is 1 when a start-of-frame pixel is accepted, the previous active settings stay in force for that frame.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output pixel and its markers stay stable and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width_m1 | input | 16 | Input line width minus one |
| cfg_clip | input | 32 | Leading drop count [31:16], trailing value [15:0] |
| cfg_bypass | input | 1 | Forward the stream unchanged |
| cfg_hold | input | 1 | Keep the active settings at frame start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | Input start-of-frame marker |
| in_eol | input | 1 | Input end-of-line marker |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eol | output | 1 | Output end-of-line marker |

## Verification
The hardest case to reach is a configuration change that arrives in the cycle right after a start-of-frame pixel is accepted. The change must then wait a whole frame before it applies. The stimulus waits for that acceptance edge before it rewrites the clip field, then sends the next frame unchanged to confirm the new settings are picked up there. A sweep over every leading and trailing count for an eight-pixel line covers windows that drop the start-of-frame pixel, windows of one pixel and empty windows. Half of the sweep runs with a periodically stalled output, which exercises the marker timing under backpressure.

// File: rtl/hcrop_pkg.sv
package hcrop_pkg;

    // Width of every count field; the clip word packs two of them.
    localparam int unsigned FIELD_W = 16;
    localparam int unsigned CLIP_W  = 2 * FIELD_W;

    typedef struct packed {
        logic [FIELD_W-1:0] width_m1;  // line width minus one
        logic [FIELD_W-1:0] left;      // pixels dropped before the window
        logic [FIELD_W-1:0] right;     // pixels after the window, minus one
        logic               bypass;
    } hcrop_cfg_t;

    // Out of reset the unit forwards everything.
    localparam hcrop_cfg_t CFG_RST = '{
        width_m1: '1,
        left:     '0,
        right:    '0,
        bypass:   1'b1
    };

endpackage

// File: rtl/hcrop_shadow.sv
module hcrop_shadow
    import hcrop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  hcrop_cfg_t cfg_in,
    input  logic       hold,
    input  logic       sof_seen,   // a start-of-frame pixel is presented
    input  logic       sof_take,   // that pixel is accepted this cycle
    output hcrop_cfg_t cur_cfg
);

    typedef struct packed {
        hcrop_cfg_t act;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof_take && !hold) begin
            st_d.act = cfg_in;
        end
        // The frame-start pixel already sees the settings it will latch.
        cur_cfg = (sof_seen && !hold) ? cfg_in : st_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a frame start without hold captures the presented settings
    p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_take && !hold |=> st_q.act == $past(cfg_in));

    // R8: no frame start, no change
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_take |=> $stable(st_q.act));

    // R9: hold keeps the old settings across a frame start
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_take && hold |=> $stable(st_q.act));

endmodule

// File: rtl/hcrop_colctl.sv
module hcrop_colctl
    import hcrop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  hcrop_cfg_t cfg,
    input  logic       in_sof,
    input  logic       in_eol,
    input  logic       take,
    output logic       keep,
    output logic       mark_sof,
    output logic       mark_eol
);

    localparam logic [FIELD_W:0] ONE_X = {{FIELD_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [FIELD_W-1:0] col;
        logic               sof_pend;
    } state_t;

    state_t st_d, st_q;

    logic [FIELD_W-1:0] col_cur;
    logic [FIELD_W:0]   tail;
    logic               byp_eff;
    logic               pend_cur;
    logic               in_win;
    logic               at_last;

    always_comb begin
        byp_eff  = cfg.bypass || ((cfg.left == '0) && (cfg.right == '1));
        col_cur  = in_sof ? '0 : st_q.col;
        // column plus trailing value, one bit wider so it cannot wrap
        tail     = {1'b0, col_cur} + {1'b0, cfg.right};
        in_win   = (col_cur >= cfg.left) && (tail < {1'b0, cfg.width_m1});
        at_last  = (tail + ONE_X) == {1'b0, cfg.width_m1};
        pend_cur = in_sof || st_q.sof_pend;

        if (byp_eff) begin
            keep     = 1'b1;
            mark_sof = in_sof;
            mark_eol = in_eol;
        end else begin
            keep     = in_win;
            mark_sof = pend_cur;
            mark_eol = at_last && in_win;
        end

        st_d = st_q;
        if (take) begin
            st_d.col      = in_eol ? '0 : col_cur + 1'b1;
            st_d.sof_pend = keep ? 1'b0 : pend_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.col      <= '0;
            st_q.sof_pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: once a pixel is forwarded, no frame-start marker is left pending
    p_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && keep |=> !st_q.sof_pend);

endmodule

// File: rtl/hcrop_outreg.sv
module hcrop_outreg #(
    parameter int unsigned PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PIX_W-1:0] ld_data,
    input  logic             ld_sof,
    input  logic             ld_eol,
    input  logic             out_ready,
    output logic             can_take,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_eol
);

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] data;
        logic             sof;
        logic             eol;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        can_take = !st_q.valid || out_ready;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.data  = ld_data;
            st_d.sof   = ld_sof;
            st_d.eol   = ld_eol;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_sof   = st_q.sof;
    assign out_eol   = st_q.eol;

    // R10: a stalled output pixel does not move
    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_sof) && $stable(out_eol));

endmodule

// File: rtl/hcrop_unit.sv
module hcrop_unit
    import hcrop_pkg::*;
#(
    parameter int unsigned PIX_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_W-1:0]  cfg_width_m1,
    input  logic [CLIP_W-1:0]   cfg_clip,
    input  logic                cfg_bypass,
    input  logic                cfg_hold,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PIX_W-1:0]    in_data,
    input  logic                in_sof,
    input  logic                in_eol,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [PIX_W-1:0]    out_data,
    output logic                out_sof,
    output logic                out_eol
);

    hcrop_cfg_t cfg_bus;
    hcrop_cfg_t cur_cfg;
    logic       take;
    logic       keep;
    logic       mark_sof;
    logic       mark_eol;
    logic       can_take;

    // The leading count sits in the upper half of the clip word.
    assign cfg_bus = '{
        width_m1: cfg_width_m1,
        left:     cfg_clip[CLIP_W-1:FIELD_W],
        right:    cfg_clip[FIELD_W-1:0],
        bypass:   cfg_bypass
    };

    assign in_ready = can_take;
    assign take     = in_valid && can_take;

    hcrop_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_in   (cfg_bus),
        .hold     (cfg_hold),
        .sof_seen (in_valid && in_sof),
        .sof_take (take && in_sof),
        .cur_cfg  (cur_cfg)
    );

    hcrop_colctl u_colctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cur_cfg),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .take     (take),
        .keep     (keep),
        .mark_sof (mark_sof),
        .mark_eol (mark_eol)
    );

    hcrop_outreg #(.PIX_W(PIX_W)) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take && keep),
        .ld_data   (in_data),
        .ld_sof    (mark_sof),
        .ld_eol    (mark_eol),
        .out_ready (out_ready),
        .can_take  (can_take),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eol   (out_eol)
    );

    // R2: a dropped pixel never fills the output register
    p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && !keep |=> out_valid == $past(out_valid && !out_ready));

    // R10: a stalled output blocks the input
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/sim_hcrop_unit.sv
module sim_hcrop_unit;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_width_m1 = 16'd7;
    logic [31:0]   cfg_clip = '0;
    logic          cfg_bypass = 1'b0;
    logic          cfg_hold = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_data = '0;
    logic          in_sof = 1'b0;
    logic          in_eol = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [PW-1:0] out_data;
    logic          out_sof;
    logic          out_eol;

    always #2 clk = ~clk;   // 250 MHz

    hcrop_unit #(.PIX_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_width_m1(cfg_width_m1), .cfg_clip(cfg_clip),
        .cfg_bypass(cfg_bypass), .cfg_hold(cfg_hold), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    int             n_chk = 0;
    int             n_bad = 0;
    string          tag = "R1";
    logic [PW+1:0]  exp_q[$];
    bit             stall = 1'b0;
    int             out_cnt = 0;
    int             frame_no = 0;
    logic [15:0]    act_w = 16'hFFFF;
    logic [31:0]    act_clip = '0;
    logic           act_byp = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Expected output of one frame, from the requirements only.
    task automatic model_frame(input int w, input int l);
        int  left, right;
        bit  byp, first;
        if (!cfg_hold) begin
            act_w = cfg_width_m1; act_clip = cfg_clip; act_byp = cfg_bypass;
        end
        left  = int'(act_clip[31:16]);
        right = int'(act_clip[15:0]);
        byp   = act_byp || (left == 0 && right == 65535);
        first = 1'b1;
        for (int ln = 0; ln < l; ln++) begin
            for (int c = 0; c < w; c++) begin
                bit k, e;
                logic [PW-1:0] d;
                d = {6'(frame_no), 5'(ln), 5'(c)};
                if (byp) begin
                    k = 1'b1; e = (c == w - 1);
                end else begin
                    k = (c >= left) && (c + right + 1 < int'(act_w) + 1);
                    e = k && (c + right + 1 == int'(act_w));
                end
                if (k) begin
                    exp_q.push_back({first, e, d});
                    first = 1'b0;
                end
            end
        end
    endtask

    task automatic put(input logic [PW-1:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eol = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic send_frame(input int w, input int l, input bit chg,
                              input logic [31:0] mid_clip);
        model_frame(w, l);
        for (int ln = 0; ln < l; ln++) begin
            for (int c = 0; c < w; c++) begin
                put({6'(frame_no), 5'(ln), 5'(c)}, ln == 0 && c == 0, c == w - 1);
                if (chg && ln == 0 && c == 0) begin
                    @(posedge clk);
                    #1;
                    cfg_clip = mid_clip;   // just after the frame start is taken
                end
            end
        end
        frame_no++;
    endtask

    task automatic drain(input string req);
        int t = 0;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        while (exp_q.size() != 0 && t < 500) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, req, "expected beats not seen", exp_q.size(), 0);
    endtask

    // Output side: drives out_ready, compares every accepted beat.
    initial begin : monitor
        int            cyc = 0;
        bit            held = 1'b0;
        logic [PW+1:0] saved = '0;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            #2;
            if (rst_n) begin
                if (held) begin
                    check(out_valid && ({out_sof, out_eol, out_data} == saved), "R10",
                          "stalled beat changed", int'({out_sof, out_eol, out_data}), int'(saved));
                end
                if (out_valid && out_ready) begin
                    out_cnt++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, tag, "unexpected beat", int'({out_sof, out_eol, out_data}), -1);
                    end else begin
                        logic [PW+1:0] ev;
                        ev = exp_q.pop_front();
                        check({out_sof, out_eol, out_data} == ev, tag, "beat {sof,eol,data}",
                              int'({out_sof, out_eol, out_data}), int'(ev));
                    end
                end
                held  = out_valid && !out_ready;
                saved = {out_sof, out_eol, out_data};
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin : stimulus
        repeat (5) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R2 R4 R5: every leading/trailing pair on an 8-pixel line
        tag = "R2 R4 R5";
        cfg_width_m1 = 16'd7;
        for (int lf = 0; lf < 8; lf++) begin
            for (int rt = 0; rt < 8; rt++) begin
                if (lf + rt + 1 <= 8) begin
                    stall = (lf % 2) == 1;
                    cfg_clip = {16'(lf), 16'(rt)};
                    send_frame(8, 2, 1'b0, '0);
                end
            end
        end
        drain(tag);

        // R3: L=3, T=1 on width 8 keeps columns 3..5, so 6 beats for 2 lines
        tag = "R3"; stall = 1'b1; out_cnt = 0;
        cfg_clip = {16'd3, 16'd1};
        send_frame(8, 2, 1'b0, '0);
        drain(tag);
        check(out_cnt == 6, "R3", "beats for L=3 T=1", out_cnt, 6);

        // R6: bypass ignores the clip field
        tag = "R6"; stall = 1'b1;
        cfg_bypass = 1'b1; cfg_width_m1 = 16'd5; cfg_clip = {16'd2, 16'd1};
        send_frame(6, 3, 1'b0, '0);
        drain(tag);
        cfg_bypass = 1'b0;

        // R7: full-width window equals bypass
        tag = "R7"; stall = 1'b0;
        cfg_width_m1 = 16'd4; cfg_clip = {16'd0, 16'hFFFF};
        send_frame(5, 2, 1'b0, '0);
        drain(tag);

        // R8: a change just after frame start waits for the next frame
        tag = "R8";
        cfg_width_m1 = 16'd7; cfg_clip = {16'd1, 16'd1};
        send_frame(8, 2, 1'b1, {16'd0, 16'd4});
        send_frame(8, 2, 1'b0, '0);
        drain(tag);

        // R9: hold keeps the old window, release picks up the new one
        tag = "R9";
        cfg_clip = {16'd2, 16'd2};
        send_frame(8, 1, 1'b0, '0);
        cfg_hold = 1'b1; cfg_clip = {16'd5, 16'd0}; cfg_bypass = 1'b1;
        send_frame(8, 2, 1'b0, '0);
        cfg_hold = 1'b0; cfg_bypass = 1'b0;
        send_frame(8, 2, 1'b0, '0);
        drain(tag);

        summary();
        $finish;
    end

endmodule